// File: doc/BRIEF.md
# Bit-Aligned Type A Receive Deframer

This block sits behind a demodulator that has already turned the ISO14443A carrier into a stream of bits. For each frame it receives a start strobe, a run of single-cycle bit strobes (data bits and, when enabled, one odd-parity bit after every full byte), each carrying a collision marker, and finally an end strobe. It packs the data bits least-significant-bit first into bytes and emits each byte as soon as its last data bit arrives.

During anticollision a card may answer with a split byte. A 3-bit alignment value, sampled with the start strobe, names the bit position inside the first output byte where the first received bit lands. Lower positions of that byte read as zero, and the parity bit that closes such a shortened byte is not checked. The block also reports where the first collision of the frame happened, as a position number, and keeps sticky collision, parity and framing error flags that are cleared by the next start strobe. On the end strobe any unfinished byte is emitted together with a count of the bits it holds.

Top module: `rxa_deframer`

## Requirements
- R1: Data bits fill a byte LSB first. The first data bit of a frame goes to bit position `align_i` (sampled with `sof_i`). Positions below it read 0. A byte is output (`byte_valid_o`=1, `byte_o`, `byte_bits_o` = number of bits received into it, i.e. 8-`align_i` for the first byte and 8 afterwards) one cycle after its bit 7 is received.
- R2: With `par_en_i`=1 at the start strobe, one parity bit follows each full byte. The bit is correct when the XOR of the 8 data bits and the parity bit is 1. A wrong parity bit on a checked byte sets `par_err_o` one cycle later.
- R3: When `align_i` is nonzero, the parity bit after the first byte is consumed but not checked.
- R4: With `par_en_i`=0 at the start strobe, no parity bits are expected, and the bit after a full byte is bit 0 of the next byte.
- R5: Data bits are numbered 1, 2, 3 … in order of arrival regardless of alignment. A collision marker on a data bit sets `coll_err_o`, and `coll_pos_o` takes that bit's number if it is the first collision of the frame.
- R6: A collision marker on a parity bit sets `coll_err_o` and `par_err_o`, and the reported position is the number of the last data bit of that byte (8·n for byte n when unaligned).
- R7: A start strobe with `sof_coll_i`=1 gives `coll_pos_o`=0 with `coll_err_o`=1 and `frm_err_o`=1.
- R8: Only the first collision of a frame sets `coll_pos_o`. Later collisions leave it unchanged.
- R9: `sof_bad_i` with the start strobe, or `eof_bad_i` with the end strobe, sets `frm_err_o`.
- R10: After reset, and one cycle after every start strobe, the error flags and `coll_pos_o` are 0 (apart from R7/R9 effects of that strobe). Otherwise the flags stay set until the next start strobe.
- R11: One cycle after the end strobe, `done_o` pulses. If bits of an unfinished byte are pending, that byte is output in the same cycle with `byte_bits_o` equal to their count. Otherwise no byte is output.
- R12: Bit and end strobes outside a frame have no effect on any output. A bit strobe in the same cycle as `sof_i` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_i | input | 3 | First-bit position of the first byte, sampled with sof_i |
| par_en_i | input | 1 | Parity bits present and checked, sampled with sof_i |
| sof_i | input | 1 | Start-of-frame strobe |
| sof_coll_i | input | 1 | Collision seen during start of frame |
| sof_bad_i | input | 1 | Malformed start of frame |
| bit_valid_i | input | 1 | Received bit strobe |
| bit_data_i | input | 1 | Received bit value |
| bit_coll_i | input | 1 | Collision marker for this bit |
| eof_i | input | 1 | End-of-frame strobe |
| eof_bad_i | input | 1 | Malformed end of frame |
| byte_valid_o | output | 1 | Output byte strobe |
| byte_o | output | 8 | Output byte |
| byte_bits_o | output | 4 | Received bits held in byte_o |
| done_o | output | 1 | Frame end pulse |
| coll_err_o | output | 1 | Collision flag |
| par_err_o | output | 1 | Parity error flag |
| frm_err_o | output | 1 | Framing error flag |
| coll_pos_o | output | 8 | Position of first collision |

## Verification
Every result is registered once: a byte, a flag change, the collision position and the done pulse all appear exactly one clock after the edge that captures the bit, parity bit or strobe causing them. The bench drives each strobe just after a falling edge, lets one rising edge capture it, and samples all outputs at the following falling edge before driving anything new. This makes a missing, early or repeated byte pulse visible at the exact bit that should cause it. Parity and collision flags are compared right after each parity bit and again after the end strobe, against a model that walks the same bit sequence.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;
  typedef struct packed {
    logic coll;
    logic par;
    logic frm;
  } rx_err_t;
endpackage

// File: rtl/rxa_byte_asm.sv
`timescale 1ns/1ps
module rxa_byte_asm #(
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(BYTE_W),
  localparam int NB_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  align_i,
  input  logic              take_i,
  input  logic              din_i,
  input  logic              flush_i,
  output logic              full_o,
  output logic              emit_o,
  output logic [BYTE_W-1:0] emit_word_o,
  output logic [NB_W-1:0]   emit_bits_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc;
  logic [BYTE_W-1:0] merged;
  logic [PTR_W-1:0]  ptr;
  logic [NB_W-1:0]   cnt;

  always_comb begin
    merged      = acc;
    merged[ptr] = din_i;
  end

  assign full_o      = take_i && (ptr == LAST);
  assign emit_o      = full_o || (flush_i && (cnt != '0));
  assign emit_word_o = full_o ? merged : acc;
  assign emit_bits_o = full_o ? cnt + NB_W'(1) : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ptr <= '0;
      cnt <= '0;
    end else if (start_i) begin
      acc <= '0;
      ptr <= align_i;
      cnt <= '0;
    end else if (take_i) begin
      if (ptr == LAST) begin
        acc <= '0;
        ptr <= '0;
        cnt <= '0;
      end else begin
        acc <= merged;
        ptr <= ptr + PTR_W'(1);
        cnt <= cnt + NB_W'(1);
      end
    end else if (flush_i) begin
      acc <= '0;
      ptr <= '0;
      cnt <= '0;
    end
  end
endmodule

// File: rtl/rxa_par_chk.sv
`timescale 1ns/1ps
module rxa_par_chk #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] data_i,
  input  logic              par_i,
  output logic              ok_o
);
  // odd parity: data bits plus parity bit hold an odd number of ones
  assign ok_o = ^{data_i, par_i};
endmodule

// File: rtl/rxa_err_track.sv
`timescale 1ns/1ps
module rxa_err_track
  import rxa_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             sof_coll_i,
  input  logic             sof_bad_i,
  input  logic             dcoll_i,
  input  logic             pcoll_i,
  input  logic             par_bad_i,
  input  logic             eof_bad_i,
  input  logic [POS_W-1:0] pos_now_i,
  output rx_err_t          err_o,
  output logic [POS_W-1:0] pos_o
);
  rx_err_t          err_q;
  logic [POS_W-1:0] pos_q;
  logic             any_coll;

  assign any_coll = dcoll_i || pcoll_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
      pos_q <= '0;
    end else if (sof_i) begin
      err_q.coll <= sof_coll_i;
      err_q.par  <= 1'b0;
      err_q.frm  <= sof_bad_i || sof_coll_i;
      pos_q      <= '0;
    end else begin
      if (any_coll && !err_q.coll) pos_q <= pos_now_i;
      if (any_coll) err_q.coll <= 1'b1;
      if (pcoll_i || par_bad_i) err_q.par <= 1'b1;
      if (eof_bad_i) err_q.frm <= 1'b1;
    end
  end

  assign err_o = err_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/rxa_deframer.sv
`timescale 1ns/1ps
module rxa_deframer
  import rxa_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int POS_W  = 8,
  localparam int PTR_W = $clog2(BYTE_W),
  localparam int NB_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  align_i,
  input  logic              par_en_i,
  input  logic              sof_i,
  input  logic              sof_coll_i,
  input  logic              sof_bad_i,
  input  logic              bit_valid_i,
  input  logic              bit_data_i,
  input  logic              bit_coll_i,
  input  logic              eof_i,
  input  logic              eof_bad_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [NB_W-1:0]   byte_bits_o,
  output logic              done_o,
  output logic              coll_err_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic [POS_W-1:0]  coll_pos_o
);
  logic              in_frame, expect_par, first_byte, par_skip, par_en_q;
  logic [PTR_W-1:0]  align_q;
  logic [POS_W-1:0]  dcount;
  logic [BYTE_W-1:0] last_byte;

  logic              take, ptake, eof_ok;
  logic              full, emit;
  logic [BYTE_W-1:0] emit_word;
  logic [NB_W-1:0]   emit_bits;
  logic              par_ok, par_bad;
  logic [POS_W-1:0]  pos_now;
  rx_err_t           err;

  assign take    = in_frame && bit_valid_i && !expect_par && !sof_i;
  assign ptake   = in_frame && bit_valid_i &&  expect_par && !sof_i;
  assign eof_ok  = in_frame && eof_i && !sof_i;
  assign par_bad = ptake && !bit_coll_i && !par_skip && !par_ok;
  assign pos_now = take ? dcount + POS_W'(1) : dcount;

  rxa_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (sof_i),
    .align_i     (align_i),
    .take_i      (take),
    .din_i       (bit_data_i),
    .flush_i     (eof_ok),
    .full_o      (full),
    .emit_o      (emit),
    .emit_word_o (emit_word),
    .emit_bits_o (emit_bits)
  );

  rxa_par_chk #(.BYTE_W(BYTE_W)) u_par (
    .data_i (last_byte),
    .par_i  (bit_data_i),
    .ok_o   (par_ok)
  );

  rxa_err_track #(.POS_W(POS_W)) u_err (
    .clk        (clk),
    .rst        (rst),
    .sof_i      (sof_i),
    .sof_coll_i (sof_coll_i),
    .sof_bad_i  (sof_bad_i),
    .dcoll_i    (take && bit_coll_i),
    .pcoll_i    (ptake && bit_coll_i),
    .par_bad_i  (par_bad),
    .eof_bad_i  (eof_ok && eof_bad_i),
    .pos_now_i  (pos_now),
    .err_o      (err),
    .pos_o      (coll_pos_o)
  );

  assign coll_err_o = err.coll;
  assign par_err_o  = err.par;
  assign frm_err_o  = err.frm;

  // frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      expect_par <= 1'b0;
      first_byte <= 1'b0;
      par_skip   <= 1'b0;
      par_en_q   <= 1'b0;
      align_q    <= '0;
      dcount     <= '0;
      last_byte  <= '0;
    end else if (sof_i) begin
      in_frame   <= 1'b1;
      expect_par <= 1'b0;
      first_byte <= 1'b1;
      par_skip   <= 1'b0;
      par_en_q   <= par_en_i;
      align_q    <= align_i;
      dcount     <= '0;
    end else begin
      if (take) begin
        dcount <= dcount + POS_W'(1);
        if (full) begin
          expect_par <= par_en_q;
          last_byte  <= emit_word;
          par_skip   <= first_byte && (align_q != '0);
          first_byte <= 1'b0;
        end
      end
      if (ptake) expect_par <= 1'b0;
      if (eof_ok) begin
        in_frame   <= 1'b0;
        expect_par <= 1'b0;
      end
    end
  end

  // registered byte outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      byte_bits_o  <= '0;
      done_o       <= 1'b0;
    end else begin
      byte_valid_o <= emit && !sof_i;
      done_o       <= eof_ok;
      if (emit && !sof_i) begin
        byte_o      <= emit_word;
        byte_bits_o <= emit_bits;
      end
    end
  end
endmodule

// File: rtl/rxa_deframer_chk.sv
`timescale 1ns/1ps
module rxa_deframer_chk #(
  parameter int POS_W = 8,
  parameter int NB_W  = 4,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sof_i,
  input logic             sof_coll_i,
  input logic             sof_bad_i,
  input logic             bit_valid_i,
  input logic             bit_coll_i,
  input logic             eof_i,
  input logic             eof_bad_i,
  input logic             byte_valid_o,
  input logic [NB_W-1:0]  byte_bits_o,
  input logic             done_o,
  input logic             coll_err_o,
  input logic             par_err_o,
  input logic             frm_err_o,
  input logic [POS_W-1:0] coll_pos_o
);
  p_sof_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !sof_coll_i && !sof_bad_i) |=>
      (!coll_err_o && !par_err_o && !frm_err_o && coll_pos_o == '0));

  p_sof_coll_r7: assert property (@(posedge clk) disable iff (rst)
    (sof_i && sof_coll_i) |=> (coll_err_o && frm_err_o && coll_pos_o == '0));

  p_first_pos_r8: assert property (@(posedge clk) disable iff (rst)
    (coll_err_o && !sof_i) |=> $stable(coll_pos_o));

  p_bits_range_r1: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> (byte_bits_o != '0 && byte_bits_o <= NB_W'(BYTE_W)));

  p_par_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (par_err_o && !sof_i) |=> par_err_o);

  p_done_src_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(eof_i));

  p_byte_src_r12: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> $past(bit_valid_i || eof_i));

  p_coll_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_err_o) |-> $past((bit_valid_i && bit_coll_i) || (sof_i && sof_coll_i)));

  p_frm_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_err_o) |-> $past((sof_i && (sof_bad_i || sof_coll_i)) || (eof_i && eof_bad_i)));
endmodule

bind rxa_deframer rxa_deframer_chk #(.POS_W(POS_W), .NB_W(NB_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sof_i        (sof_i),
  .sof_coll_i   (sof_coll_i),
  .sof_bad_i    (sof_bad_i),
  .bit_valid_i  (bit_valid_i),
  .bit_coll_i   (bit_coll_i),
  .eof_i        (eof_i),
  .eof_bad_i    (eof_bad_i),
  .byte_valid_o (byte_valid_o),
  .byte_bits_o  (byte_bits_o),
  .done_o       (done_o),
  .coll_err_o   (coll_err_o),
  .par_err_o    (par_err_o),
  .frm_err_o    (frm_err_o),
  .coll_pos_o   (coll_pos_o)
);

// File: tb/rxa_deframer_test.sv
`timescale 1ns/1ps
module rxa_deframer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] align_i = '0;
  logic       par_en_i = 1'b0;
  logic       sof_i = 1'b0, sof_coll_i = 1'b0, sof_bad_i = 1'b0;
  logic       bit_valid_i = 1'b0, bit_data_i = 1'b0, bit_coll_i = 1'b0;
  logic       eof_i = 1'b0, eof_bad_i = 1'b0;
  logic       byte_valid_o, done_o, coll_err_o, par_err_o, frm_err_o;
  logic [7:0] byte_o, coll_pos_o;
  logic [3:0] byte_bits_o;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  rxa_deframer uut (
    .clk(clk), .rst(rst), .align_i(align_i), .par_en_i(par_en_i),
    .sof_i(sof_i), .sof_coll_i(sof_coll_i), .sof_bad_i(sof_bad_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .bit_coll_i(bit_coll_i),
    .eof_i(eof_i), .eof_bad_i(eof_bad_i),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .byte_bits_o(byte_bits_o),
    .done_o(done_o), .coll_err_o(coll_err_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o), .coll_pos_o(coll_pos_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic c);
    bit_valid_i = 1'b1; bit_data_i = b; bit_coll_i = c;
    tick();
    bit_valid_i = 1'b0; bit_data_i = 1'b0; bit_coll_i = 1'b0;
  endtask

  // Drives one frame and checks it against the requirement model.
  task automatic run_frame(input int align, input bit pe, input int nbits,
                           input logic [63:0] data, input logic [63:0] dcoll,
                           input logic [7:0] pflip, input logic [7:0] pcoll,
                           input bit scoll, input bit sbad, input bit ebad);
    int ptr, cnt, bi;
    logic [7:0] cur;
    bit eseen, ecoll, epar, efrm;
    int epos;
    eseen = scoll; ecoll = scoll; efrm = scoll | sbad; epar = 0; epos = 0;
    align_i = 3'(align); par_en_i = pe;
    sof_i = 1; sof_coll_i = scoll; sof_bad_i = sbad;
    tick();
    sof_i = 0; sof_coll_i = 0; sof_bad_i = 0;
    check("R10 coll clear at sof", coll_err_o, ecoll);
    check("R10 par clear at sof", par_err_o, 0);
    check("R9 frm at sof", frm_err_o, efrm);
    check("R7 pos at sof", coll_pos_o, 0);
    ptr = align; cnt = 0; bi = 0; cur = '0;
    for (int i = 0; i < nbits; i++) begin
      cur[ptr] = data[i];
      cnt++;
      if (dcoll[i]) begin
        ecoll = 1;
        if (!eseen) begin eseen = 1; epos = i + 1; end
      end
      send_bit(data[i], dcoll[i]);
      if (ptr == 7) begin
        check("R1 byte strobe", byte_valid_o, 1);
        check("R1 byte value", byte_o, cur);
        check("R1 byte bit count", byte_bits_o, cnt);
        if (pe) begin
          logic pb;
          pb = (~^cur) ^ pflip[bi];
          if (pcoll[bi]) begin
            ecoll = 1; epar = 1;
            if (!eseen) begin eseen = 1; epos = i + 1; end
          end else if (pflip[bi] && !(bi == 0 && align != 0)) begin
            epar = 1;
          end
          send_bit(pb, pcoll[bi]);
          if (bi == 0 && align != 0)
            check("R3 first byte parity exempt", par_err_o, epar);
          else if (pcoll[bi])
            check("R6 parity collision sets par", par_err_o, epar);
          else
            check("R2 parity flag", par_err_o, epar);
          check("R2 no byte on parity bit", byte_valid_o, 0);
        end
        ptr = 0; cnt = 0; cur = '0; bi++;
      end else begin
        check(pe ? "R1 no early byte" : "R4 no early byte", byte_valid_o, 0);
        ptr++;
      end
    end
    eof_i = 1; eof_bad_i = ebad;
    tick();
    eof_i = 0; eof_bad_i = 0;
    efrm = efrm | ebad;
    check("R11 done pulse", done_o, 1);
    check("R11 partial byte strobe", byte_valid_o, (cnt != 0) ? 1 : 0);
    if (cnt != 0) begin
      check("R11 partial byte value", byte_o, cur);
      check("R11 partial bit count", byte_bits_o, cnt);
    end
    check("R5 coll flag", coll_err_o, ecoll);
    check("R8 first coll position", coll_pos_o, epos);
    check("R2 final par flag", par_err_o, epar);
    check("R9 final frm flag", frm_err_o, efrm);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R10 reset byte strobe", byte_valid_o, 0);
    check("R10 reset coll", coll_err_o, 0);
    check("R10 reset pos", coll_pos_o, 0);
    check("R10 reset done", done_o, 0);

    // plain frame, unaligned parity on
    run_frame(0, 1, 24, 64'h00000000_00F456AC, '0, '0, '0, 0, 0, 0);
    // aligned start: flipped parity on first byte ignored (R3)
    run_frame(5, 1, 19, 64'h00000000_0005A5F3, '0, 8'h01, '0, 0, 0, 0);
    // unaligned: flipped parity on first byte is flagged (R2)
    run_frame(0, 1, 16, 64'h00000000_0000C095, '0, 8'h01, '0, 0, 0, 0);

    // R12: stray strobes after a frame must not touch outputs
    send_bit(1'b1, 1'b1);
    check("R12 stray bit no byte", byte_valid_o, 0);
    check("R12 stray coll ignored", coll_err_o, 0);
    check("R12 par flag held", par_err_o, 1);
    eof_i = 1; tick(); eof_i = 0;
    check("R12 stray eof no done", done_o, 0);

    // R7: collision during start of frame
    run_frame(0, 1, 12, 64'h0000000000000ABC, '0, '0, '0, 1, 0, 0);
    // R8: two data collisions, first one kept (bit 4 then bit 12)
    run_frame(0, 1, 20, 64'h00000000000F0F0F, 64'h0000000000000808, '0, '0, 0, 0, 0);
    // R6: collision on parity of second byte reports 16
    run_frame(0, 1, 24, 64'h0000000000123456, '0, '0, 8'h02, 0, 0, 0);
    // R6 with alignment 3: parity of first byte collides at its last bit (5)
    run_frame(3, 1, 13, 64'h0000000000001F2E, '0, '0, 8'h01, 0, 0, 0);
    // R4 + R11: parity off, partial tail
    run_frame(0, 0, 20, 64'h00000000000BEEF1, '0, '0, '0, 0, 0, 0);
    // R9: malformed start and end
    run_frame(2, 0, 6, 64'h000000000000003A, '0, '0, '0, 0, 1, 0);
    run_frame(0, 1, 8, 64'h00000000000000E7, '0, '0, '0, 0, 0, 1);

    // R12: bit in the same cycle as sof is discarded
    align_i = 0; par_en_i = 0;
    sof_i = 1; bit_valid_i = 1; bit_data_i = 1; bit_coll_i = 1;
    tick();
    sof_i = 0; bit_valid_i = 0; bit_data_i = 0; bit_coll_i = 0;
    check("R12 sof bit coll ignored", coll_err_o, 0);
    for (int k = 0; k < 8; k++) send_bit(1'b0, 1'b0);
    check("R12 sof bit not packed strobe", byte_valid_o, 1);
    check("R12 sof bit not packed value", byte_o, 0);
    eof_i = 1; tick(); eof_i = 0;
    check("R11 eof without pending bits", byte_valid_o, 0);

    // constrained random frames
    for (int f = 0; f < 60; f++) begin
      int al, nb;
      bit pe, sc, sb, eb;
      logic [63:0] d, dc;
      logic [7:0] pf, pc;
      al = $urandom_range(0, 7);
      pe = 1'($urandom_range(0, 1));
      nb = $urandom_range(1, 48);
      d  = {$urandom, $urandom};
      dc = '0;
      for (int k = 0; k < 48; k++) dc[k] = ($urandom_range(0, 31) == 0);
      pf = '0; pc = '0;
      for (int k = 0; k < 8; k++) begin
        pf[k] = ($urandom_range(0, 3) == 0);
        pc[k] = ($urandom_range(0, 15) == 0);
      end
      sc = ($urandom_range(0, 9) == 0);
      sb = ($urandom_range(0, 9) == 0);
      eb = ($urandom_range(0, 9) == 0);
      run_frame(al, pe, nb, d, dc, pf, pc, sc, sb, eb);
      repeat ($urandom_range(0, 2)) tick();
    end
    summary();
  end
endmodule